// File: doc/BRIEF.md
# CDR Lock and Loss-of-Signal Supervisor

This block watches over a clock-and-data-recovery loop in a SONET/SDH receiver. It runs in two clock domains. One is a reference clock, which is nominally 19.44 MHz. The other is the recovered line clock, which is modelled here as a digital clock. Over fixed windows of reference cycles, the block counts recovered-clock edges and compares the count with the value the selected line rate implies. At 622.08 Mb/s the recovered clock runs 32 times the reference; at 155.52 Mb/s it runs 8 times the reference. The block also tracks how long the incoming serial data stays at one level. A run that is too long means the loop has nothing to track.

From the window results and the run-length check, the block drives a lock-detect output. From two active-high signal-detect inputs, a test-bypass input and the rate select, it decides four things: loss-of-signal, a request that the loop follow the reference, whether retimed data may leave the block, and which clock feeds the clock output. In bypass, the reference clock replaces the loop: data is sampled on its rising edge and the output clock is the inverted reference.

Top module: `cdr_lock_los_ctrl`

## Requirements
- R1: `losState` and `forceRef` are high exactly when `bypassReq` is low and at least one of `sigDetA`, `sigDetB` is low.
- R2: `dataOut` is 0 in three cases: while `losState` is high, while `illegalMode` is high, and while the block is still in warm-up. Otherwise, outside bypass, it carries `dataIn` retimed on `recClk`.
- R3: `lockDet` is 0 while `forceRef` is high and while `bypassReq` is high. After either condition clears, lock must be earned again through fresh windows.
- R4: With `bypassReq` and `rateHigh` both high, the following hold:
  - `clkSelRef` is 1.
  - `clkOut` is the inverse of `refClk`.
  - `dataOut` changes only on the `refClk` rising edge.
  - The signal-detect inputs have no effect.
- R5: `illegalMode` is 1 exactly when `bypassReq` is high and `rateHigh` is low. In that mode `clkSelRef` is 0 and `dataOut` is 0.
- R6: A window lasts `WIN_CYCLES` reference cycles. `lockDet` rises only after `LOCK_WINDOWS` (default 2) consecutive windows whose recovered-edge count is within tolerance of the expected count, which is `WIN_CYCLES` times 32 (rate high) or times 8 (rate low). A single qualifying window is not enough.
- R7: The tolerance is the expected count times 500 ppm, rounded to the nearest count. An offset of about 200 ppm keeps lock. An offset of about 1000 ppm drops it after one failing window.
- R8: `RUN_LIMIT` (default 128) consecutive identical bits on `dataIn` force `lockDet` to 0 within a few reference cycles. Lock returns only after two new good windows.
- R9: Retimed data is blocked, and windows do not count towards lock, until `WARMUP_CYCLES` (default 40) reference cycles have passed since reset.
- R10: While `rstN` is low, `lockDet` and `dataOut` are 0.
- R11: With `rateHigh` low, a recovered clock at 8 times the reference earns lock, and one at 32 times the reference does not.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock |
| recClk | input | 1 | Recovered line clock |
| rstN | input | 1 | Asynchronous active-low reset, both domains |
| rateHigh | input | 1 | 1 selects 622.08 Mb/s, 0 selects 155.52 Mb/s |
| sigDetA | input | 1 | Signal detect, active high |
| sigDetB | input | 1 | Second signal detect, active high |
| bypassReq | input | 1 | Test bypass request |
| dataIn | input | 1 | Serial line data |
| lockDet | output | 1 | Loop locked to data |
| losState | output | 1 | Loss-of-signal state |
| forceRef | output | 1 | Request that the loop track the reference |
| illegalMode | output | 1 | Bypass requested at the low rate |
| clkSelRef | output | 1 | Clock output sourced from the reference |
| dataOut | output | 1 | Retimed, gated data |
| clkOut | output | 1 | Recovered clock, or inverted reference in bypass |

## Verification
The hardest state to reach is lock lost through frequency drift while the data stays healthy. It needs a whole window measured at an off-nominal recovered frequency, with the handshake carrying consistent samples from both sides. The bench reaches it by changing the half period of the recovered clock with femtosecond resolution, using one step inside tolerance and one step outside. It then waits two complete windows before it samples, so the window in which the change happened cannot decide the result. Run-length faults come from freezing the data generator for slightly more than the limit.

// File: rtl/cdr_lock_pkg.sv
package cdr_lock_pkg;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic passData;   // retimed line data may reach the output
    logic bypassAct;  // reference clock replaces the loop
  } dpCtrl_t;

  // Measurement results from the datapath to the control.
  typedef struct packed {
    logic done;       // one-cycle pulse: a window result is ready
    logic good;       // that window's count was within tolerance
    logic runFault;   // a run-length violation is present (ref domain)
  } winEvt_t;

endpackage

// File: rtl/cdr_lock_dp.sv
module cdr_lock_dp
  import cdr_lock_pkg::*;
#(
  parameter int WIN_CYCLES = 8192,
  parameter int RATIO_HIGH = 32,
  parameter int RATIO_LOW  = 8,
  parameter int PPM_LIMIT  = 500,
  parameter int RUN_LIMIT  = 128
) (
  input  logic    refClk,
  input  logic    recClk,
  input  logic    rstN,
  input  logic    rateHigh,
  input  logic    dataIn,
  input  dpCtrl_t ctl,
  output winEvt_t evt,
  output logic    dataOut,
  output logic    clkOut
);

  localparam int WIN_W  = $clog2(WIN_CYCLES);
  localparam int EXP_HI = WIN_CYCLES * RATIO_HIGH;
  localparam int EXP_LO = WIN_CYCLES * RATIO_LOW;
  localparam int TOL_HI = (EXP_HI * PPM_LIMIT + 500000) / 1000000;
  localparam int TOL_LO = (EXP_LO * PPM_LIMIT + 500000) / 1000000;
  localparam int CNT_W  = $clog2(EXP_HI) + 2;
  localparam int RUN_W  = $clog2(RUN_LIMIT + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
  localparam logic [CNT_W-1:0] HI_MIN = CNT_W'(EXP_HI - TOL_HI);
  localparam logic [CNT_W-1:0] HI_MAX = CNT_W'(EXP_HI + TOL_HI);
  localparam logic [CNT_W-1:0] LO_MIN = CNT_W'(EXP_LO - TOL_LO);
  localparam logic [CNT_W-1:0] LO_MAX = CNT_W'(EXP_LO + TOL_LO);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LIMIT);

  // ---------------- recovered-clock domain ----------------
  logic [CNT_W-1:0] freeCnt, holdCnt;
  logic [2:0]       reqSync;
  logic             reqEdge, ackTog;
  logic [RUN_W-1:0] runCnt, runNext;
  logic             prevBit, runFaultRec, recData;
  logic             reqTog;

  assign reqEdge = reqSync[2] ^ reqSync[1];

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      freeCnt <= '0;
      holdCnt <= '0;
      reqSync <= '0;
      ackTog  <= 1'b0;
    end else begin
      freeCnt <= freeCnt + 1'b1;
      reqSync <= {reqSync[1:0], reqTog};
      if (reqEdge) begin
        holdCnt <= freeCnt;
        ackTog  <= ~ackTog;
      end
    end
  end

  always_comb begin
    if (dataIn != prevBit)       runNext = RUN_W'(1);
    else if (runCnt == RUN_MAX)  runNext = runCnt;
    else                         runNext = runCnt + 1'b1;
  end

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      runCnt      <= '0;
      prevBit     <= 1'b0;
      runFaultRec <= 1'b0;
      recData     <= 1'b0;
    end else begin
      runCnt      <= runNext;
      prevBit     <= dataIn;
      runFaultRec <= (runNext == RUN_MAX);
      recData     <= dataIn;
    end
  end

  // ---------------- reference-clock domain ----------------
  logic [WIN_W-1:0] winCnt;
  logic [2:0]       ackSync;
  logic             ackEdge, havePrev;
  logic [CNT_W-1:0] prevSample, delta, lim0, lim1;
  logic [1:0]       runSync;
  logic             refData, doneQ, goodQ;

  assign ackEdge = ackSync[2] ^ ackSync[1];
  assign delta   = holdCnt - prevSample;
  assign lim0    = rateHigh ? HI_MIN : LO_MIN;
  assign lim1    = rateHigh ? HI_MAX : LO_MAX;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      reqTog <= 1'b0;
    end else if (winCnt == WIN_LAST) begin
      winCnt <= '0;
      reqTog <= ~reqTog;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      ackSync    <= '0;
      prevSample <= '0;
      havePrev   <= 1'b0;
      doneQ      <= 1'b0;
      goodQ      <= 1'b0;
      runSync    <= '0;
      refData    <= 1'b0;
    end else begin
      ackSync <= {ackSync[1:0], ackTog};
      runSync <= {runSync[0], runFaultRec};
      refData <= dataIn;
      doneQ   <= ackEdge & havePrev;
      if (ackEdge) begin
        prevSample <= holdCnt;
        havePrev   <= 1'b1;
        goodQ      <= (delta >= lim0) && (delta <= lim1);
      end
    end
  end

  assign evt.done     = doneQ;
  assign evt.good     = goodQ;
  assign evt.runFault = runSync[1];

  assign dataOut = ctl.bypassAct ? refData : (ctl.passData & recData);
  assign clkOut  = ctl.bypassAct ? ~refClk : recClk;

  // The captured count never changes except on a request edge (R6 handshake).
  assert_hold_stable_R6: assert property (@(posedge recClk) disable iff (!rstN)
    !reqEdge |=> $stable(holdCnt));

  // A window result follows its request within a short handshake latency (R6).
  assert_result_latency_R6: assert property (@(posedge refClk) disable iff (!rstN)
    doneQ |-> (winCnt < WIN_W'(16)));

endmodule

// File: rtl/cdr_lock_ctrl.sv
module cdr_lock_ctrl
  import cdr_lock_pkg::*;
#(
  parameter int LOCK_WINDOWS  = 2,
  parameter int WARMUP_CYCLES = 40
) (
  input  logic    refClk,
  input  logic    rstN,
  input  logic    rateHigh,
  input  logic    sigDetA,
  input  logic    sigDetB,
  input  logic    bypassReq,
  input  winEvt_t evt,
  output dpCtrl_t ctl,
  output logic    lockDet,
  output logic    losState,
  output logic    forceRef,
  output logic    illegalMode,
  output logic    clkSelRef
);

  localparam int ST_W = $clog2(LOCK_WINDOWS + 1);
  localparam int WU_W = $clog2(WARMUP_CYCLES + 1);
  localparam logic [ST_W-1:0] ST_FULL = ST_W'(LOCK_WINDOWS);
  localparam logic [WU_W-1:0] WU_END  = WU_W'(WARMUP_CYCLES);

  logic [WU_W-1:0] warmCnt;
  logic [ST_W-1:0] streak;
  logic            ready, block, bypassAct;

  assign losState    = (~sigDetA | ~sigDetB) & ~bypassReq;
  assign forceRef    = losState;
  assign illegalMode = bypassReq & ~rateHigh;
  assign bypassAct   = bypassReq & rateHigh;
  assign clkSelRef   = bypassAct;
  assign ready       = (warmCnt == WU_END);

  assign ctl.bypassAct = bypassAct;
  assign ctl.passData  = ready & ~losState & ~illegalMode;

  assign block = forceRef | bypassReq | evt.runFault | ~ready;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)          warmCnt <= '0;
    else if (!ready)    warmCnt <= warmCnt + 1'b1;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                 streak <= '0;
    else if (block)            streak <= '0;
    else if (evt.done) begin
      if (!evt.good)           streak <= '0;
      else if (streak != ST_FULL) streak <= streak + 1'b1;
    end
  end

  assign lockDet = (streak == ST_FULL) & ~block;

  assert_no_lock_in_los_R3: assert property (@(posedge refClk) disable iff (!rstN)
    forceRef |-> !lockDet);

  assert_lock_after_window_R6: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockDet) |-> $past(evt.done && evt.good));

  assert_runfault_unlocks_R8: assert property (@(posedge refClk) disable iff (!rstN)
    evt.runFault |-> !lockDet);

  assert_illegal_blocks_R5: assert property (@(posedge refClk) disable iff (!rstN)
    illegalMode |-> (!ctl.passData && !ctl.bypassAct && !clkSelRef));

endmodule

// File: rtl/cdr_lock_los_ctrl.sv
module cdr_lock_los_ctrl
  import cdr_lock_pkg::*;
#(
  parameter int WIN_CYCLES    = 8192,
  parameter int RATIO_HIGH    = 32,
  parameter int RATIO_LOW     = 8,
  parameter int PPM_LIMIT     = 500,
  parameter int RUN_LIMIT     = 128,
  parameter int LOCK_WINDOWS  = 2,
  parameter int WARMUP_CYCLES = 40
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  input  logic rateHigh,
  input  logic sigDetA,
  input  logic sigDetB,
  input  logic bypassReq,
  input  logic dataIn,
  output logic lockDet,
  output logic losState,
  output logic forceRef,
  output logic illegalMode,
  output logic clkSelRef,
  output logic dataOut,
  output logic clkOut
);

  dpCtrl_t ctl;
  winEvt_t evt;

  cdr_lock_ctrl #(
    .LOCK_WINDOWS (LOCK_WINDOWS),
    .WARMUP_CYCLES(WARMUP_CYCLES)
  ) uCtrl (
    .refClk     (refClk),
    .rstN       (rstN),
    .rateHigh   (rateHigh),
    .sigDetA    (sigDetA),
    .sigDetB    (sigDetB),
    .bypassReq  (bypassReq),
    .evt        (evt),
    .ctl        (ctl),
    .lockDet    (lockDet),
    .losState   (losState),
    .forceRef   (forceRef),
    .illegalMode(illegalMode),
    .clkSelRef  (clkSelRef)
  );

  cdr_lock_dp #(
    .WIN_CYCLES(WIN_CYCLES),
    .RATIO_HIGH(RATIO_HIGH),
    .RATIO_LOW (RATIO_LOW),
    .PPM_LIMIT (PPM_LIMIT),
    .RUN_LIMIT (RUN_LIMIT)
  ) uDp (
    .refClk  (refClk),
    .recClk  (recClk),
    .rstN    (rstN),
    .rateHigh(rateHigh),
    .dataIn  (dataIn),
    .ctl     (ctl),
    .evt     (evt),
    .dataOut (dataOut),
    .clkOut  (clkOut)
  );

endmodule

// File: tb/tb_cdr_lock_los_ctrl.sv
module tb_cdr_lock_los_ctrl;
  timeunit 1ns;
  timeprecision 1fs;

  localparam real HALF_32   = 0.078125;
  localparam real HALF_8    = 0.3125;
  localparam real HALF_NEAR = 0.0781406;  // about 200 ppm slow
  localparam real HALF_FAR  = 0.078203;   // about 1000 ppm slow

  logic refClk = 1'b0, recClk = 1'b0, rstN = 1'b0;
  logic rateHigh = 1'b1, sigDetA = 1'b1, sigDetB = 1'b1, bypassReq = 1'b0;
  logic dataIn = 1'b0;
  logic lockDet, losState, forceRef, illegalMode, clkSelRef, dataOut, clkOut;

  real  recHalf = HALF_32;
  logic genOn = 1'b1, constVal = 1'b0;
  logic [6:0] lfsr = 7'h5A;
  int checks = 0, errors = 0;
  bit finished = 0;

  cdr_lock_los_ctrl #(.WIN_CYCLES(1024)) dut (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .rateHigh(rateHigh),
    .sigDetA(sigDetA), .sigDetB(sigDetB), .bypassReq(bypassReq), .dataIn(dataIn),
    .lockDet(lockDet), .losState(losState), .forceRef(forceRef),
    .illegalMode(illegalMode), .clkSelRef(clkSelRef), .dataOut(dataOut), .clkOut(clkOut)
  );

  initial forever #2.5 refClk = ~refClk;
  initial forever #(recHalf) recClk = ~recClk;

  initial forever begin
    @(negedge recClk);
    lfsr   <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    dataIn <= genOn ? lfsr[0] : constVal;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitRef(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  // {rateHigh, bypassReq, sigDetA, sigDetB, expLos, expIllegal, expSelRef, expPass}
  localparam logic [7:0] VEC [10] = '{
    8'b1011_0001, 8'b1001_1000, 8'b1010_1000, 8'b1000_1000, 8'b1100_0011,
    8'b0011_0001, 8'b0001_1000, 8'b0010_1000, 8'b0111_0100, 8'b0100_0100
  };

  initial begin
    #(300000 * 5.0);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    waitRef(5);
    check(lockDet == 0, "R10", "lockDet in reset", lockDet, 0);
    check(dataOut == 0, "R10", "dataOut in reset", dataOut, 0);
    @(negedge refClk) rstN = 1'b1;

    // R9: warm-up gating
    genOn = 0; constVal = 1;
    waitRef(10);
    check(dataOut == 0, "R9", "dataOut during warm-up", dataOut, 0);
    waitRef(40);
    check(dataOut == 1, "R9", "dataOut after warm-up", dataOut, 1);
    genOn = 1;

    // R6: one good window is not enough, two are
    waitRef(2550);
    check(lockDet == 0, "R6", "lockDet after one window", lockDet, 0);
    waitRef(700);
    check(lockDet == 1, "R6", "lockDet after two windows", lockDet, 1);

    // R8: run-length fault
    genOn = 0; constVal = 0;
    waitRef(10);
    check(lockDet == 0, "R8", "lockDet on long run", lockDet, 0);
    genOn = 1;
    waitRef(10);
    check(lockDet == 0, "R8", "lockDet right after run ends", lockDet, 0);
    waitRef(2200);
    check(lockDet == 1, "R8", "lockDet requalified", lockDet, 1);

    // R7: tolerance edges
    recHalf = HALF_NEAR;
    waitRef(2100);
    check(lockDet == 1, "R7", "lockDet at ~200ppm", lockDet, 1);
    recHalf = HALF_FAR;
    waitRef(2100);
    check(lockDet == 0, "R7", "lockDet at ~1000ppm", lockDet, 0);
    recHalf = HALF_32;
    waitRef(3200);
    check(lockDet == 1, "R7", "lockDet back at nominal", lockDet, 1);

    // R1/R2/R3: loss of signal with live data
    sigDetB = 0;
    waitRef(1);
    check(lockDet == 0, "R3", "lockDet in LOS", lockDet, 0);
    check(forceRef == 1, "R1", "forceRef in LOS", forceRef, 1);
    for (int i = 0; i < 4; i++) begin
      #0.4;
      check(dataOut == 0, "R2", "dataOut in LOS", dataOut, 0);
    end
    sigDetB = 1;
    waitRef(5);
    check(lockDet == 0, "R3", "lockDet after LOS clears", lockDet, 0);

    // Control table walk (R1, R2, R4, R5)
    genOn = 0; constVal = 1;
    for (int v = 0; v < 10; v++) begin
      {rateHigh, bypassReq, sigDetA, sigDetB} = VEC[v][7:4];
      waitRef(3);
      check(losState == VEC[v][3], "R1", $sformatf("losState vec %0d", v), losState, VEC[v][3]);
      check(forceRef == VEC[v][3], "R1", $sformatf("forceRef vec %0d", v), forceRef, VEC[v][3]);
      check(illegalMode == VEC[v][2], "R5", $sformatf("illegalMode vec %0d", v), illegalMode, VEC[v][2]);
      check(clkSelRef == VEC[v][1], "R4", $sformatf("clkSelRef vec %0d", v), clkSelRef, VEC[v][1]);
      check(dataOut == VEC[v][0], "R2", $sformatf("dataOut vec %0d", v), dataOut, VEC[v][0]);
    end

    // R4: bypass at the high rate
    rateHigh = 1; bypassReq = 1; sigDetA = 0; sigDetB = 0; constVal = 0;
    waitRef(2);
    check(dataOut == 0, "R4", "bypass data low", dataOut, 0);
    check(clkOut == 0, "R4", "clkOut with refClk high", clkOut, 0);
    check(lockDet == 0, "R3", "lockDet in bypass", lockDet, 0);
    constVal = 1;
    #1;
    check(dataOut == 0, "R4", "bypass data waits for ref edge", dataOut, 0);
    #1.5;
    check(clkOut == 1, "R4", "clkOut with refClk low", clkOut, 1);
    waitRef(1);
    check(dataOut == 1, "R4", "bypass data after ref edge", dataOut, 1);
    bypassReq = 0; sigDetA = 1; sigDetB = 1;

    // R11: low line rate
    rateHigh = 0; genOn = 1;
    waitRef(2200);
    check(lockDet == 0, "R11", "lockDet low rate, 32x clock", lockDet, 0);
    recHalf = HALF_8;
    waitRef(3300);
    check(lockDet == 1, "R11", "lockDet low rate, 8x clock", lockDet, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule